// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block follows the chain of extended capability headers kept in a 4 KB configuration space. The space is reached through a single-port memory that holds 32-bit words and returns read data one cycle after the read. A search always begins at byte offset 0x100 and follows the 12-bit next pointers until one of three things happens: a header carries the requested ID, the chain ends, or a pointer is found to be invalid.

A search key of zero never matches, so it returns the last header of the chain. An append operation uses that result. It adds a new header by rewriting only the next-pointer field of the current last header, then writes the new header. A host asserts `start` for one cycle with the operation and its operands. It reads the result while `done` is high, and the result stays valid until the next accepted start.

Top module: `capWalker`

## Requirements
- R1: After reset `done`, `error`, `memRe` and `memWe` are low, and `foundOffset` and `prevOffset` are 0.
- R2: Every walk reads the word at byte offset 0x100 first. A header of all zeros there means the chain is empty: a search reports `foundOffset` 0, `prevOffset` 0 and no error.
- R3: A header holds the ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A search for a nonzero key reports, in `foundOffset`, the first header whose ID equals the key. It reports in `prevOffset` the header visited just before that one, or 0 if the match is at 0x100.
- R4: A search that reaches a next offset of 0 without a match reports `foundOffset` 0 and `prevOffset` equal to the last header. A key of 0 always ends this way.
- R5: A nonzero next offset below 0x100 or above 0xFF8 stops the walk with `error` high. On any error both offsets read 0.
- R6: A walk that would visit more than MAX_HOPS headers stops with `error` high. This covers a chain that loops back on itself.
- R7: The memory address is the byte offset divided by 4. Each read is a one-cycle `memRe` pulse, and its data is decoded in the following cycle. Every read address lies within byte offsets 0x100 to 0xFF8.
- R8: An append at 0x100 rewrites the word at 0x100 with its old bits 31:20 kept and the new version and ID below them. It then reports `foundOffset` 0x100 and `prevOffset` 0.
- R9: An append at any other offset first changes only bits 31:20 of the last header, setting them to the new offset. It then writes the new header with next field 0 and reports `foundOffset` equal to the new offset and `prevOffset` equal to the old last header.
- R10: An append is rejected with `error` and no memory write if the offset is below 0x100, the offset is not a multiple of 4, the size is under 8, or offset plus size is 0x1000 or more.
- R11: An append away from 0x100 onto an empty or broken chain is rejected with `error` and no memory write.
- R12: `done` is high for exactly one cycle. The results hold until the next accepted start, and `start` is ignored while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (one-cycle pulse) |
| opAppend | input | 1 | 0 = search, 1 = append |
| keyId | input | 16 | ID to search for (0 finds the last header) |
| newOffset | input | 12 | Byte offset of the header to append |
| newSize | input | 12 | Byte length of the capability to append |
| newId | input | 16 | ID of the appended header |
| newVer | input | 4 | Version of the appended header |
| done | output | 1 | Result valid, one-cycle pulse |
| foundOffset | output | 12 | Matching or appended offset, 0 if none |
| prevOffset | output | 12 | Previously visited or last header offset |
| error | output | 1 | Operation stopped on an invalid pointer, hop limit or bad append |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 10 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid one cycle after `memRe` |

## Verification
For a search, or for an append that finds the last header, `done` rises a fixed number of clock edges after the start edge. A search that visits n headers finishes after 1 + 2n edges, counting an empty chain as one visit. An append at 0x100 finishes after 5 edges, an append elsewhere after 4 + 2n, and a rejected append after 2. The bench drives `start` on a falling edge and counts falling edges until it sees `done`. It compares that count with the expected figure for each error-free search and for the directed append cases. Offsets and the memory image are checked in the same half-cycle window, and the image is compared word by word against a reference copy.

// File: rtl/capWalkPkg.sv
package capWalkPkg;
  localparam int OFF_W     = 12;
  localparam int WADDR_W   = OFF_W - 2;
  localparam int ID_W      = 16;
  localparam int VER_W     = 4;
  localparam logic [OFF_W-1:0] BASE_OFF = 12'h100;
  localparam logic [OFF_W-1:0] LAST_OFF = 12'hFF8;
  localparam logic [OFF_W:0]   SPACE_END = 13'h1000;
  localparam logic [OFF_W-1:0] MIN_SIZE = 12'd8;

  typedef struct packed {
    logic loadBase;
    logic advance;
    logic latchHdr;
    logic resEmpty;
    logic resFound;
    logic resTail;
    logic resAppend;
    logic resErr;
    logic wrTail;
    logic wrNew;
  } dpCmd_t;

  typedef struct packed {
    logic hdrZero;
    logic idMatch;
    logic nextZero;
    logic nextBad;
    logic hopsOut;
    logic firstHop;
    logic appendBad;
    logic newAtBase;
  } dpStat_t;
endpackage

// File: rtl/capWalkData.sv
module capWalkData
  import capWalkPkg::*;
#(
  parameter int MAX_HOPS = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [ID_W-1:0]     keyIn,
  input  logic [OFF_W-1:0]    newOffIn,
  input  logic [OFF_W-1:0]    newSizeIn,
  input  logic [ID_W-1:0]     newIdIn,
  input  logic [VER_W-1:0]    newVerIn,
  input  logic [31:0]         memRdata,
  output dpStat_t             stat,
  output logic [WADDR_W-1:0]  memAddr,
  output logic [31:0]         memWdata,
  output logic [OFF_W-1:0]    foundOffset,
  output logic [OFF_W-1:0]    prevOffset,
  output logic                errFlag
);
  localparam int HOP_W = $clog2(MAX_HOPS) + 1;

  logic [OFF_W-1:0] cur, prevReg, newOff, newSize;
  logic [ID_W-1:0]  key, newId;
  logic [VER_W-1:0] newVer;
  logic [31:0]      hdr;
  logic [HOP_W-1:0] hops;
  logic [OFF_W-1:0] nextPtr;

  assign nextPtr = memRdata[31:20];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0; prevReg <= '0; newOff <= '0; newSize <= '0;
      key <= '0; newId <= '0; newVer <= '0; hdr <= '0; hops <= '0;
      foundOffset <= '0; prevOffset <= '0; errFlag <= 1'b0;
    end else begin
      if (cmd.loadBase) begin
        cur <= BASE_OFF; prevReg <= '0; hops <= '0;
        key <= keyIn; newOff <= newOffIn; newSize <= newSizeIn;
        newId <= newIdIn; newVer <= newVerIn;
        foundOffset <= '0; prevOffset <= '0; errFlag <= 1'b0;
      end
      if (cmd.latchHdr) hdr <= memRdata;
      if (cmd.advance) begin
        prevReg <= cur;
        cur     <= nextPtr;
        hops    <= hops + 1'b1;
      end
      if (cmd.resEmpty) begin foundOffset <= '0; prevOffset <= '0; end
      if (cmd.resFound) begin foundOffset <= cur; prevOffset <= prevReg; end
      if (cmd.resTail)  begin foundOffset <= '0; prevOffset <= cur; end
      if (cmd.resAppend) begin
        foundOffset <= newOff;
        prevOffset  <= stat.newAtBase ? '0 : cur;
      end
      if (cmd.resErr) begin
        foundOffset <= '0; prevOffset <= '0; errFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    stat.hdrZero   = (memRdata == '0);
    stat.idMatch   = (key != '0) && (memRdata[ID_W-1:0] == key);
    stat.nextZero  = (nextPtr == '0);
    stat.nextBad   = (nextPtr < BASE_OFF) || (nextPtr > LAST_OFF);
    stat.hopsOut   = (hops == HOP_W'(MAX_HOPS - 1));
    stat.firstHop  = (hops == '0);
    stat.newAtBase = (newOff == BASE_OFF);
    stat.appendBad = (newOff < BASE_OFF) || (newOff[1:0] != 2'b00) ||
                     (newSize < MIN_SIZE) ||
                     (({1'b0, newOff} + {1'b0, newSize}) >= SPACE_END);
  end

  always_comb begin
    memAddr  = cmd.wrNew ? newOff[OFF_W-1:2] : cur[OFF_W-1:2];
    memWdata = cmd.wrTail ? {newOff, hdr[19:0]}
                          : {(stat.newAtBase ? hdr[31:20] : 12'h000), newVer, newId};
  end
endmodule

// File: rtl/capWalkCtrl.sv
module capWalkCtrl
  import capWalkPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opAppend,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    memRe,
  output logic    memWe,
  output logic    done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_DECODE, S_WTAIL, S_WNEW, S_FIN
  } state_t;

  state_t state, nextState;
  logic   isApp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      isApp <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) isApp <= opAppend;
    end
  end

  always_comb begin
    cmd       = '0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        cmd.loadBase = 1'b1;
        nextState    = opAppend ? S_CHECK : S_READ;
      end
      S_CHECK: begin
        if (stat.appendBad) begin
          cmd.resErr = 1'b1;
          nextState  = S_FIN;
        end else begin
          nextState  = S_READ;
        end
      end
      S_READ: begin
        memRe     = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        cmd.latchHdr = 1'b1;
        if (isApp && stat.newAtBase) begin
          nextState = S_WNEW;
        end else if (stat.firstHop && stat.hdrZero) begin
          if (isApp) cmd.resErr = 1'b1;
          else       cmd.resEmpty = 1'b1;
          nextState = S_FIN;
        end else if (!isApp && stat.idMatch) begin
          cmd.resFound = 1'b1;
          nextState    = S_FIN;
        end else if (stat.nextZero) begin
          if (isApp) nextState = S_WTAIL;
          else begin
            cmd.resTail = 1'b1;
            nextState   = S_FIN;
          end
        end else if (stat.nextBad || stat.hopsOut) begin
          cmd.resErr = 1'b1;
          nextState  = S_FIN;
        end else begin
          cmd.advance = 1'b1;
          nextState   = S_READ;
        end
      end
      S_WTAIL: begin
        memWe      = 1'b1;
        cmd.wrTail = 1'b1;
        nextState  = S_WNEW;
      end
      S_WNEW: begin
        memWe         = 1'b1;
        cmd.wrNew     = 1'b1;
        cmd.resAppend = 1'b1;
        nextState     = S_FIN;
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/capWalker.sv
module capWalker
  import capWalkPkg::*;
#(
  parameter int MAX_HOPS = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        opAppend,
  input  logic [15:0] keyId,
  input  logic [11:0] newOffset,
  input  logic [11:0] newSize,
  input  logic [15:0] newId,
  input  logic [3:0]  newVer,
  output logic        done,
  output logic [11:0] foundOffset,
  output logic [11:0] prevOffset,
  output logic        error,
  output logic        memRe,
  output logic        memWe,
  output logic [9:0]  memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata
);
  dpCmd_t  cmd;
  dpStat_t stat;

  capWalkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opAppend(opAppend),
    .stat(stat), .cmd(cmd), .memRe(memRe), .memWe(memWe), .done(done)
  );

  capWalkData #(.MAX_HOPS(MAX_HOPS)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .keyIn(keyId), .newOffIn(newOffset), .newSizeIn(newSize),
    .newIdIn(newId), .newVerIn(newVer), .memRdata(memRdata),
    .stat(stat), .memAddr(memAddr), .memWdata(memWdata),
    .foundOffset(foundOffset), .prevOffset(prevOffset), .errFlag(error)
  );
endmodule

// File: rtl/capWalkChk.sv
module capWalkChk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        error,
  input logic        memRe,
  input logic        memWe,
  input logic [9:0]  memAddr,
  input logic [11:0] foundOffset,
  input logic [11:0] prevOffset
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  read_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> (!memRe && !memWe));
  // R7
  read_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> (memAddr >= 10'h040 && memAddr <= 10'h3FE));
  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (foundOffset == 12'h000 && prevOffset == 12'h000));
  // R3
  found_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error) |-> (foundOffset[1:0] == 2'b00 && prevOffset[1:0] == 2'b00));
  // R10
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !memWe);
endmodule

bind capWalker capWalkChk uChk (
  .clk(clk), .rstN(rstN), .done(done), .error(error), .memRe(memRe),
  .memWe(memWe), .memAddr(memAddr), .foundOffset(foundOffset),
  .prevOffset(prevOffset)
);

// File: tb/tb_capWalker.sv
module tb_capWalker;
  localparam int MAXH = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opAppend = 1'b0;
  logic [15:0] keyId = '0;
  logic [11:0] newOffset = '0;
  logic [11:0] newSize = '0;
  logic [15:0] newId = '0;
  logic [3:0]  newVer = '0;
  logic        done, error, memRe, memWe;
  logic [11:0] foundOffset, prevOffset;
  logic [9:0]  memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  logic [31:0] mem    [1024];
  logic [31:0] expMem [1024];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int lat;

  always #4 clk = ~clk;

  capWalker #(.MAX_HOPS(MAXH)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opAppend(opAppend),
    .keyId(keyId), .newOffset(newOffset), .newSize(newSize),
    .newId(newId), .newVer(newVer), .done(done),
    .foundOffset(foundOffset), .prevOffset(prevOffset), .error(error),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference search over expMem: returns found, prev, error, visit count
  function automatic void refSearch(input logic [15:0] key,
                                    output logic [11:0] f, output logic [11:0] p,
                                    output bit e, output int visits);
    logic [11:0] cur = 12'h100;
    logic [11:0] prv = 12'h000;
    logic [31:0] h;
    logic [11:0] nx;
    f = 0; p = 0; e = 0; visits = 0;
    for (int hop = 0; hop < MAXH + 2; hop++) begin
      h = expMem[cur[11:2]];
      visits = visits + 1;
      if (hop == 0 && h == 32'h0) return;
      if (key != 16'h0 && h[15:0] == key) begin f = cur; p = prv; return; end
      nx = h[31:20];
      if (nx == 12'h0) begin p = cur; return; end
      if (nx < 12'h100 || nx > 12'hFF8 || hop == MAXH - 1) begin e = 1; return; end
      prv = cur;
      cur = nx;
    end
  endfunction

  function automatic void refAppend(input logic [11:0] off, input logic [11:0] sz,
                                    input logic [15:0] id, input logic [3:0] ver,
                                    output logic [11:0] f, output logic [11:0] p,
                                    output bit e);
    logic [11:0] ff, tail;
    bit          ee;
    int          v;
    f = 0; p = 0; e = 0;
    if (off < 12'h100 || off[1:0] != 2'b00 || sz < 12'd8 ||
        ({1'b0, off} + {1'b0, sz}) >= 13'h1000) begin e = 1; return; end
    if (off == 12'h100) begin
      expMem[12'h100 >> 2] = {expMem[12'h100 >> 2][31:20], ver, id};
      f = 12'h100;
      return;
    end
    refSearch(16'h0, ff, tail, ee, v);
    if (ee || tail == 12'h0) begin e = 1; return; end
    expMem[tail[11:2]] = {off, expMem[tail[11:2]][19:0]};
    expMem[off[11:2]]  = {12'h000, ver, id};
    f = off; p = tail;
  endfunction

  task automatic snapshot();
    for (int i = 0; i < 1024; i++) expMem[i] = mem[i];
  endtask

  task automatic compareMem(input string req);
    int bad = -1;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expMem[i] && bad < 0) bad = i;
    if (bad < 0) check(1'b1, req, "memory image", 0, 0);
    else check(1'b0, req, $sformatf("memory word %0h", bad), mem[bad], expMem[bad]);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  // run one operation; lat = falling edges from start until done seen
  task automatic runOp(input bit app, input logic [15:0] key,
                       input logic [11:0] off, input logic [11:0] sz,
                       input logic [15:0] id, input logic [3:0] ver);
    @(negedge clk);
    opAppend = app; keyId = key; newOffset = off; newSize = sz;
    newId = id; newVer = ver; start = 1'b1;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  // build a chain of n headers: 0x100 first, others in distinct 0x40 slots
  task automatic buildChain(input int n, input int r, output logic [15:0] ids [8]);
    logic [11:0] offs [8];
    clearMem();
    offs[0] = 12'h100;
    for (int i = 1; i < n; i++) offs[i] = 12'h100 + 12'(((r + i * 13) % 59 + 1) * 64);
    for (int i = 0; i < n; i++) begin
      ids[i] = 16'($urandom_range(1, 16'hFFFF));
      mem[offs[i][11:2]] = {(i == n - 1) ? 12'h000 : offs[i + 1],
                            4'($urandom_range(0, 15)), ids[i]};
    end
  endtask

  task automatic doSearch(input logic [15:0] key, input string req, input bit chkLat);
    logic [11:0] ef, ep;
    bit          ee;
    int          v;
    snapshot();
    refSearch(key, ef, ep, ee, v);
    runOp(1'b0, key, 12'h0, 12'h0, 16'h0, 4'h0);
    check(done === 1'b1, req, "done seen", done, 1);
    check(error === ee, req, "error", error, ee);
    check(foundOffset === ef, req, "foundOffset", foundOffset, ef);
    check(prevOffset === ep, req, "prevOffset", prevOffset, ep);
    if (chkLat && !ee) check(lat == 1 + 2 * v, "R7", "search latency", lat, 1 + 2 * v);
  endtask

  task automatic doAppend(input logic [11:0] off, input logic [11:0] sz,
                          input logic [15:0] id, input logic [3:0] ver, input string req);
    logic [11:0] ef, ep;
    bit          ee;
    snapshot();
    refAppend(off, sz, id, ver, ef, ep, ee);
    runOp(1'b1, 16'h0, off, sz, id, ver);
    check(error === ee, req, "append error", error, ee);
    check(foundOffset === ef, req, "append foundOffset", foundOffset, ef);
    check(prevOffset === ep, req, "append prevOffset", prevOffset, ep);
    compareMem(req);
  endtask

  initial begin
    logic [15:0] ids [8];
    logic [11:0] keepF;
    void'($urandom(32'h5eed_c0de));
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done === 1'b0 && error === 1'b0, "R1", "done/error at reset", {done, error}, 0);
    check(memRe === 1'b0 && memWe === 1'b0, "R1", "mem strobes at reset", {memRe, memWe}, 0);
    check(foundOffset === 12'h0 && prevOffset === 12'h0, "R1", "offsets at reset",
          {foundOffset, prevOffset}, 0);
    rstN = 1'b1;

    // R2 empty chain
    doSearch(16'h1234, "R2", 1'b1);
    check(lat == 3, "R2", "empty latency", lat, 3);

    // R3 match at 0x100, prev 0, latency 3
    buildChain(1, 0, ids);
    doSearch(ids[0], "R3", 1'b1);
    check(lat == 3, "R7", "single hop latency", lat, 3);

    // R3/R4 three-header chain
    buildChain(3, 5, ids);
    doSearch(ids[2], "R3", 1'b1);
    check(lat == 7, "R7", "three hop latency", lat, 7);
    doSearch(16'h0, "R4", 1'b1);

    // R12 results held after done
    keepF = prevOffset;
    repeat (5) @(negedge clk);
    check(prevOffset === keepF && done === 1'b0, "R12", "result hold", prevOffset, keepF);

    // R5 bad pointers
    clearMem();
    mem[12'h100 >> 2] = {12'h0F0, 4'h1, 16'h0011};
    doSearch(16'h0099, "R5", 1'b0);
    mem[12'h100 >> 2] = {12'hFFC, 4'h1, 16'h0011};
    doSearch(16'h0099, "R5", 1'b0);

    // R6 self loop, and R12 start ignored while busy
    clearMem();
    mem[12'h100 >> 2] = {12'h100, 4'h2, 16'h0005};
    snapshot();
    @(negedge clk);
    opAppend = 1'b0; keyId = 16'h0007; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    opAppend = 1'b1; newOffset = 12'h100; newSize = 12'h10; newId = 16'hAAAA;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat = lat + 1; end
    check(done === 1'b1 && error === 1'b1, "R6", "hop limit error", {done, error}, 3);
    check(foundOffset === 12'h0, "R12", "busy start ignored", foundOffset, 0);
    compareMem("R12");

    // R8 append at base on non-empty chain, latency 5
    buildChain(2, 9, ids);
    doAppend(12'h100, 12'h20, 16'hBEEF, 4'h3, "R8");
    check(lat == 5, "R8", "base append latency", lat, 5);

    // R9 append elsewhere, latency 4+2n
    buildChain(3, 17, ids);
    doAppend(12'hE00, 12'h40, 16'hCAFE, 4'h2, "R9");
    check(lat == 10, "R9", "tail append latency", lat, 10);
    doSearch(16'hCAFE, "R9", 1'b1);

    // R10 rejected appends
    doAppend(12'hE02, 12'h40, 16'h1, 4'h1, "R10");
    doAppend(12'h0FC, 12'h40, 16'h1, 4'h1, "R10");
    doAppend(12'hE00, 12'h004, 16'h1, 4'h1, "R10");
    doAppend(12'hFF0, 12'h010, 16'h1, 4'h1, "R10");
    check(lat == 2, "R10", "reject latency", lat, 2);

    // R11 append onto empty chain away from base
    clearMem();
    doAppend(12'h200, 12'h10, 16'h2, 4'h1, "R11");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int n = $urandom_range(1, 7);
      buildChain(n, $urandom_range(0, 58), ids);
      if ($urandom_range(0, 1) == 0) begin
        logic [15:0] k = ($urandom_range(0, 2) == 0) ? 16'($urandom) : ids[$urandom_range(0, n - 1)];
        doSearch(k, "R3", 1'b1);
      end else begin
        logic [11:0] o = 12'($urandom_range(0, 12'hFFF));
        if ($urandom_range(0, 3) != 0) o[1:0] = 2'b00;
        doAppend(o, 12'($urandom_range(0, 12'h200)), 16'($urandom), 4'($urandom), "R9");
      end
    end

    finishRun();
  end
endmodule